// File: doc/BRIEF.md
# Sticky Comparison Response Analyzer Chain

This block compares the responses of pairs of identical blocks under test during a built-in self-test. Every analyzer cell takes one pair of response words, one from block j and one from block k. It XORs them bit by bit and reduces the differences to a single mismatch signal. That signal is ORed into the cell's own pass/fail flip-flop, so a single disagreement is held until the flop is cleared. A 1 in a flop reports a failure and a 0 reports a pass.

The cell flip-flops also form a serial scan chain. When shift mode is high, comparison stops. Each flop then takes the value of its lower-indexed neighbour, and cell 0 takes the serial input. The highest-indexed cell drives the serial output, so a tester reads the results with the highest cell first. A synchronous clear empties every flop at the start of a session. A compare enable keeps the flops from capturing while the pattern pipeline is still filling.

Top module: `resp_cmp_chain`

## Requirements
- R1: While rst is high and on the edge after it, every bit of fail_vec and scan_out is 0.
- R2: On an edge where clear=0, shift_mode=0 and cmp_en=1, fail_vec[i] becomes 1 if any bit of resp_j slice i (bits i*PAIR_W up to i*PAIR_W+PAIR_W-1) differs from the same bit of resp_k.
- R3: A fail_vec bit that is 1 stays 1 on every edge where clear=0 and shift_mode=0, whatever the response data.
- R4: A fail_vec bit stays 0 while its two response slices are equal, even when cmp_en=1.
- R5: With cmp_en=0, clear=0 and shift_mode=0, fail_vec does not change, even when the responses differ.
- R6: clear=1 sets every fail_vec bit to 0 on the next edge. It takes priority over shift_mode and cmp_en.
- R7: With shift_mode=1 and clear=0, cell i loads the old fail_vec[i-1] and cell 0 loads scan_in. Response mismatches have no effect on that edge.
- R8: scan_out always equals fail_vec[NUM_ORA-1].
- R9: When the tester samples scan_out before each of NUM_ORA shift edges, it reads cell NUM_ORA-1 first and cell 0 last.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| clear | input | 1 | Synchronous clear of all pass/fail flops |
| cmp_en | input | 1 | Enables capture of mismatches |
| shift_mode | input | 1 | Turns the flops into a shift register |
| scan_in | input | 1 | Serial input into cell 0 |
| resp_j | input | NUM_ORA*PAIR_W | Responses of the j blocks, one slice per cell |
| resp_k | input | NUM_ORA*PAIR_W | Responses of the k blocks, one slice per cell |
| fail_vec | output | NUM_ORA | Registered pass/fail flags, 1 = failure |
| scan_out | output | 1 | Serial result output from the last cell |

## Verification
The assertions assume that clear, cmp_en and shift_mode are known and do not change between clock edges. They also assume that the response buses are valid whenever capture is enabled. They check clear priority, hold and shift relative to those control inputs. The bench changes every input only on falling edges and leaves no control input undriven. It also holds the response buses at defined values in every phase, including the shift and masked phases in which deliberate mismatches are applied.

// File: rtl/ora_pkg.sv
package ora_pkg;
  typedef enum logic [1:0] {
    ORA_HOLD    = 2'd0,
    ORA_CAPTURE = 2'd1,
    ORA_SHIFT   = 2'd2,
    ORA_CLEAR   = 2'd3
  } ora_op_e;
endpackage

// File: rtl/ora_ctrl.sv
module ora_ctrl
  import ora_pkg::*;
(
  input  logic    clear,
  input  logic    cmp_en,
  input  logic    shift_mode,
  output ora_op_e op
);
  // Priority: clear, then shift, then capture.
  always_comb begin
    if (clear)           op = ORA_CLEAR;
    else if (shift_mode) op = ORA_SHIFT;
    else if (cmp_en)     op = ORA_CAPTURE;
    else                 op = ORA_HOLD;
  end
endmodule

// File: rtl/ora_mismatch.sv
module ora_mismatch #(
  parameter int PAIR_W = 8
) (
  input  logic [PAIR_W-1:0] a,
  input  logic [PAIR_W-1:0] b,
  output logic              miss
);
  logic [PAIR_W-1:0] diff;
  assign diff = a ^ b;
  assign miss = |diff;
endmodule

// File: rtl/ora_cell.sv
module ora_cell
  import ora_pkg::*;
(
  input  logic    clk,
  input  logic    rst,
  input  ora_op_e op,
  input  logic    miss,
  input  logic    shift_in,
  output logic    fail_q
);
  always_ff @(posedge clk) begin
    if (rst) fail_q <= 1'b0;
    else begin
      unique case (op)
        ORA_CLEAR:   fail_q <= 1'b0;
        ORA_SHIFT:   fail_q <= shift_in;
        ORA_CAPTURE: fail_q <= fail_q | miss;
        default:     fail_q <= fail_q;
      endcase
    end
  end

  p_capture_r2: assert property (@(posedge clk) disable iff (rst)
    (op == ORA_CAPTURE && miss) |=> fail_q);
  p_sticky_r3: assert property (@(posedge clk) disable iff (rst)
    (fail_q && (op == ORA_CAPTURE || op == ORA_HOLD)) |=> fail_q);
  p_masked_r5: assert property (@(posedge clk) disable iff (rst)
    (op == ORA_HOLD) |=> $stable(fail_q));
  p_clear_r6: assert property (@(posedge clk) disable iff (rst)
    (op == ORA_CLEAR) |=> !fail_q);
  p_shift_r7: assert property (@(posedge clk) disable iff (rst)
    (op == ORA_SHIFT) |=> (fail_q == $past(shift_in)));
endmodule

// File: rtl/resp_cmp_chain.sv
module resp_cmp_chain
  import ora_pkg::*;
#(
  parameter int NUM_ORA = 4,
  parameter int PAIR_W  = 8
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        clear,
  input  logic                        cmp_en,
  input  logic                        shift_mode,
  input  logic                        scan_in,
  input  logic [NUM_ORA*PAIR_W-1:0]   resp_j,
  input  logic [NUM_ORA*PAIR_W-1:0]   resp_k,
  output logic [NUM_ORA-1:0]          fail_vec,
  output logic                        scan_out
);
  localparam int LAST = NUM_ORA - 1;

  ora_op_e            op;
  logic [NUM_ORA-1:0] miss;
  logic [NUM_ORA-1:0] chain_in;

  ora_ctrl u_ctrl (
    .clear      (clear),
    .cmp_en     (cmp_en),
    .shift_mode (shift_mode),
    .op         (op)
  );

  for (genvar i = 0; i < NUM_ORA; i++) begin : g_cell
    if (i == 0) begin : g_head
      assign chain_in[i] = scan_in;
    end else begin : g_link
      assign chain_in[i] = fail_vec[i-1];
    end

    ora_mismatch #(.PAIR_W(PAIR_W)) u_cmp (
      .a    (resp_j[i*PAIR_W +: PAIR_W]),
      .b    (resp_k[i*PAIR_W +: PAIR_W]),
      .miss (miss[i])
    );

    ora_cell u_cell (
      .clk      (clk),
      .rst      (rst),
      .op       (op),
      .miss     (miss[i]),
      .shift_in (chain_in[i]),
      .fail_q   (fail_vec[i])
    );
  end

  assign scan_out = fail_vec[LAST];

  p_reset_r1: assert property (@(posedge clk) rst |=> (fail_vec == '0));
endmodule

// File: tb/resp_cmp_chain_tb_top.sv
module resp_cmp_chain_tb_top;
  localparam int N = 4;
  localparam int W = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic clear = 1'b0, cmp_en = 1'b0, shift_mode = 1'b0, scan_in = 1'b0;
  logic [N*W-1:0] resp_j = '0, resp_k = '0;
  logic [N-1:0] fail_vec;
  logic scan_out;

  int checks = 0, errors = 0, cyc = 0;
  string tag = "R1";
  bit model [N];

  always #5 clk = ~clk;

  resp_cmp_chain #(.NUM_ORA(N), .PAIR_W(W)) dut_i (
    .clk(clk), .rst(rst), .clear(clear), .cmp_en(cmp_en),
    .shift_mode(shift_mode), .scan_in(scan_in),
    .resp_j(resp_j), .resp_k(resp_k),
    .fail_vec(fail_vec), .scan_out(scan_out)
  );

  task automatic check(input bit ok, input string t, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", t, act, exp, $time);
    end
  endtask

  function automatic int model_vec();
    int v = 0;
    for (int i = 0; i < N; i++) if (model[i]) v |= (1 << i);
    return v;
  endfunction

  // Behavioural reference, updated on each edge.
  always @(posedge clk) begin
    bit nxt [N];
    cyc++;
    for (int i = 0; i < N; i++) nxt[i] = model[i];
    if (rst || clear) begin
      for (int i = 0; i < N; i++) nxt[i] = 0;
    end else if (shift_mode) begin
      nxt[0] = scan_in;
      for (int i = 1; i < N; i++) nxt[i] = model[i-1];
    end else if (cmp_en) begin
      for (int i = 0; i < N; i++)
        if (resp_j[i*W +: W] != resp_k[i*W +: W]) nxt[i] = 1;
    end
    model <= nxt;
  end

  // Compare on every falling edge.
  always @(negedge clk) begin
    if (cyc >= 1) begin
      check(fail_vec == model_vec(), tag, int'(fail_vec), model_vec());
      check(scan_out == model[N-1], "R8", int'(scan_out), int'(model[N-1]));
    end
    if (cyc > 5000) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic set_diff(input int lane, input int bitpos);
    resp_k[lane*W + bitpos] = ~resp_j[lane*W + bitpos];
  endtask

  task automatic readout(input logic [N-1:0] exp);
    shift_mode = 1'b1;
    scan_in = 1'b0;
    for (int t = 0; t < N; t++) begin
      check(scan_out == exp[N-1-t], "R9", int'(scan_out), int'(exp[N-1-t]));
      step(1);
    end
    shift_mode = 1'b0;
  endtask

  initial begin
    step(3);
    check(fail_vec == '0 && scan_out == 1'b0, "R1", int'(fail_vec), 0);
    rst = 1'b0;
    step(1);
    check(fail_vec == '0, "R1", int'(fail_vec), 0);

    // R4: equal data, compare enabled
    tag = "R4";
    cmp_en = 1'b1;
    for (int p = 0; p < 5; p++) begin
      resp_j = {N{8'h5A}} ^ (p * 32'h01234567);
      resp_k = resp_j;
      step(1);
    end
    check(fail_vec == '0, "R4", int'(fail_vec), 0);

    // R5: mismatches while capture is masked
    tag = "R5";
    cmp_en = 1'b0;
    resp_k = ~resp_j;
    step(3);
    check(fail_vec == '0, "R5", int'(fail_vec), 0);

    // R2: single-bit mismatches in lanes 1 and 3
    tag = "R2";
    resp_k = resp_j;
    set_diff(1, 0);
    set_diff(3, 7);
    cmp_en = 1'b1;
    step(1);
    check(fail_vec == 4'b1010, "R2", int'(fail_vec), 4'b1010);

    // R3: flags stay set when data agrees again
    tag = "R3";
    resp_k = resp_j;
    step(4);
    check(fail_vec == 4'b1010, "R3", int'(fail_vec), 4'b1010);
    cmp_en = 1'b0;
    step(2);
    check(fail_vec == 4'b1010, "R3", int'(fail_vec), 4'b1010);

    // R9 readout, with mismatches present during shift (R7)
    tag = "R7";
    cmp_en = 1'b1;
    resp_k = ~resp_j;
    readout(4'b1010);
    check(fail_vec == '0, "R7", int'(fail_vec), 0);

    // R7: serial input enters cell 0 and moves upward
    resp_k = resp_j;
    cmp_en = 1'b0;
    shift_mode = 1'b1;
    scan_in = 1'b1; step(1);
    scan_in = 1'b0; step(1);
    scan_in = 1'b1; step(1);
    shift_mode = 1'b0; scan_in = 1'b0;
    check(fail_vec == 4'b0101, "R7", int'(fail_vec), 4'b0101);

    // R6: clear wins over shift and capture
    tag = "R6";
    cmp_en = 1'b1;
    resp_k = ~resp_j;
    step(1);
    clear = 1'b1; shift_mode = 1'b1; scan_in = 1'b1;
    step(1);
    check(fail_vec == '0, "R6", int'(fail_vec), 0);
    clear = 1'b0; shift_mode = 1'b0; scan_in = 1'b0;

    // Second session: lanes 0 and 2 fail, verify order
    tag = "R2";
    resp_k = resp_j;
    set_diff(0, 4);
    set_diff(2, 2);
    step(1);
    resp_k = resp_j;
    step(2);
    check(fail_vec == 4'b0101, "R2", int'(fail_vec), 4'b0101);
    tag = "R9";
    readout(4'b0101);

    // Reset mid-run
    tag = "R1";
    resp_k = ~resp_j;
    step(1);
    rst = 1'b1;
    step(1);
    check(fail_vec == '0, "R1", int'(fail_vec), 0);
    rst = 1'b0;
    cmp_en = 1'b0;
    step(2);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule